// File: doc/BRIEF.md
# Power-Down Hold Controller

This block sits between a logic core and its pads and freezes both sides while the chip is asleep. A configuration bit arms the feature. Once armed, a high level on either of two dedicated sleep pins makes the controller stop the core clock and hold the core's inputs at the values they had just before sleep began. It also holds the pad output values and the pad drive enables in the same way. When both sleep pins are low again, the hold is released and the live signals pass through unchanged.

Both pins go through a synchroniser to the system clock, so entry and exit fall on clock edges and the core never sees a clipped clock-enable pulse. When the feature is not armed, the two pins are plain logic inputs and reach the core through `pin_logic_o`. When it is armed, the core reads them as zero.

Top module: `pdh_ctrl`

## Requirements
- R1: After reset, `core_clk_en_o` is 1, `core_in_o` equals `pad_in_i`, `pad_out_o` equals `core_out_i`, and `pad_oe_o` equals `core_oe_i`.
- R2: With `pd_feature_en_i` = 1, a high level on either sleep pin that is sampled at clock edge t makes `core_clk_en_o` go low after edge t+SYNC_STAGES.
- R3: With `pd_feature_en_i` = 0, the sleep pins never start a hold, and `pin_logic_o` = {`pd_pin_b_i`, `pd_pin_a_i`} (bit 0 is pin A).
- R4: With `pd_feature_en_i` = 1, `pin_logic_o` is 0 whatever the pins do.
- R5: During a hold, `core_in_o` equals the value of `pad_in_i` sampled at the edge that began the hold. Changes on `pad_in_i` have no effect on it.
- R6: During a hold, `pad_out_o` equals the value of `core_out_i` sampled at the entry edge. Changes on `core_out_i` have no effect on it.
- R7: During a hold, `pad_oe_o` equals the value of `core_oe_i` sampled at the entry edge, so a pad that was disabled (0) at entry stays disabled.
- R8: `core_clk_en_o` stays 0 for every cycle of the hold.
- R9: When the armed request (feature enabled and either pin high) is sampled low at edge t, the hold ends after edge t+SYNC_STAGES and all outputs follow their live inputs again.
- R10: If both pins are high, dropping only one of them does not end the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_feature_en_i | input | 1 | Configuration bit that arms the sleep feature |
| pd_pin_a_i | input | 1 | Sleep pin A |
| pd_pin_b_i | input | 1 | Sleep pin B |
| pad_in_i | input | N_IN | Live input values from the pads |
| core_in_o | output | N_IN | Input values presented to the core |
| pin_logic_o | output | 2 | Sleep pins as logic inputs; zero when the feature is armed |
| core_clk_en_o | output | 1 | Core clock enable; 0 during a hold |
| core_out_i | input | N_OUT | Output values from the core |
| core_oe_i | input | N_OUT | Output drive enables from the core |
| pad_out_o | output | N_OUT | Output values sent to the pads |
| pad_oe_o | output | N_OUT | Drive enables sent to the pads |

## Verification
The bench looks for four kinds of error. It checks the exact entry and exit cycle: a controller with one synchroniser stage too many or too few would hold or release a cycle off. It checks the captured snapshot: a design that captured one edge late would freeze a value that arrived after sleep had begun. It overlaps the two pins, because a design that released on the fall of either pin would wake while the other pin is still high. It also toggles the pins while the feature is disarmed and while it is armed. A design that ignored the configuration bit would either hold the core or leak the pins into the logic inputs.

// File: rtl/pdh_pkg.sv
package pdh_pkg;
   typedef enum logic {
      PDH_RUN  = 1'b0,
      PDH_HOLD = 1'b1
   } pdh_state_e;

   localparam int unsigned PDH_PIN_COUNT = 2;
endpackage

// File: rtl/pdh_sync.sv
module pdh_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else if (STAGES == 1) chain_q <= d_i;
            else chain_q <= {chain_q[STAGES-2:0], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pdh_fsm.sv
module pdh_fsm
   import pdh_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   output logic active_o,
   output logic capture_o
);
   pdh_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         PDH_RUN:  if (req_i)  state_d = PDH_HOLD;
         PDH_HOLD: if (!req_i) state_d = PDH_RUN;
         default:  state_d = PDH_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= PDH_RUN;
      else         state_q <= state_d;
   end

   assign active_o  = (state_q == PDH_HOLD);
   assign capture_o = (state_q == PDH_RUN) && req_i;

   // R2: a hold only begins after the synchronised request was seen high
   a_r2_entry_needs_req : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_o && !$past(active_o)) |-> $past(req_i));
   // R9: a hold only ends after the synchronised request was seen low
   a_r9_exit_needs_drop : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(active_o) |-> !$past(req_i));
endmodule

// File: rtl/pdh_hold.sv
module pdh_hold #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             capture_i,
   input  logic             hold_i,
   input  logic [WIDTH-1:0] live_i,
   output logic [WIDTH-1:0] val_o
);
   logic [WIDTH-1:0] snap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        snap_q <= '0;
      else if (capture_i) snap_q <= live_i;
   end

   assign val_o = hold_i ? snap_q : live_i;
endmodule

// File: rtl/pdh_ctrl.sv
module pdh_ctrl
   import pdh_pkg::*;
#(
   parameter int unsigned N_IN        = 8,
   parameter int unsigned N_OUT       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     pd_feature_en_i,
   input  logic                     pd_pin_a_i,
   input  logic                     pd_pin_b_i,
   input  logic [N_IN-1:0]          pad_in_i,
   output logic [N_IN-1:0]          core_in_o,
   output logic [PDH_PIN_COUNT-1:0] pin_logic_o,
   output logic                     core_clk_en_o,
   input  logic [N_OUT-1:0]         core_out_i,
   input  logic [N_OUT-1:0]         core_oe_i,
   output logic [N_OUT-1:0]         pad_out_o,
   output logic [N_OUT-1:0]         pad_oe_o
);
   localparam int unsigned OUT_BUNDLE = 2 * N_OUT;

   generate
      if (N_IN < 1)        begin : g_bad_in   $error("N_IN must be at least 1");        end
      if (N_OUT < 1)       begin : g_bad_out  $error("N_OUT must be at least 1");       end
      if (SYNC_STAGES > 8) begin : g_bad_sync $error("SYNC_STAGES must not exceed 8"); end
   endgenerate

   logic req_raw, req_sync, active, capture;
   logic [OUT_BUNDLE-1:0] out_live, out_val;

   assign req_raw = pd_feature_en_i && (pd_pin_a_i || pd_pin_b_i);

   pdh_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_raw), .q_o(req_sync)
   );

   pdh_fsm u_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_sync),
      .active_o(active), .capture_o(capture)
   );

   pdh_hold #(.WIDTH(N_IN)) u_in_hold (
      .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(capture), .hold_i(active),
      .live_i(pad_in_i), .val_o(core_in_o)
   );

   assign out_live = {core_oe_i, core_out_i};
   pdh_hold #(.WIDTH(OUT_BUNDLE)) u_out_hold (
      .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(capture), .hold_i(active),
      .live_i(out_live), .val_o(out_val)
   );
   assign pad_out_o = out_val[N_OUT-1:0];
   assign pad_oe_o  = out_val[OUT_BUNDLE-1:N_OUT];

   assign core_clk_en_o = !active;
   assign pin_logic_o   = pd_feature_en_i ? '0 : {pd_pin_b_i, pd_pin_a_i};

   // R5: core inputs do not move while the clock stays off
   a_r5_in_frozen : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!core_clk_en_o && $past(!core_clk_en_o)) |-> $stable(core_in_o));
   // R6: pad values do not move while the clock stays off
   a_r6_out_frozen : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!core_clk_en_o && $past(!core_clk_en_o)) |-> $stable(pad_out_o));
   // R7: pad drive enables do not move while the clock stays off
   a_r7_oe_frozen : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!core_clk_en_o && $past(!core_clk_en_o)) |-> $stable(pad_oe_o));
   // R4: armed feature keeps the sleep pins out of the logic inputs
   a_r4_pins_masked : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pd_feature_en_i && (pd_pin_a_i || pd_pin_b_i)) |-> (pin_logic_o == '0));
endmodule

// File: tb/pdh_ctrl_tb.sv
module pdh_ctrl_tb;
   localparam int unsigned N_IN  = 8;
   localparam int unsigned N_OUT = 8;
   localparam int unsigned SYNC  = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en = 1'b0, pa = 1'b0, pb = 1'b0;
   logic [N_IN-1:0]  pad_in = '0;
   logic [N_OUT-1:0] c_out = '0, c_oe = '0;
   logic [N_IN-1:0]  core_in;
   logic [1:0]       pin_logic;
   logic             clk_en;
   logic [N_OUT-1:0] pad_out, pad_oe;

   int checks = 0, errors = 0;
   logic [SYNC:0]    hist = '0;
   logic             act_exp = 1'b0;
   logic [N_IN-1:0]  snap_in = '0;
   logic [N_OUT-1:0] snap_out = '0, snap_oe = '0;

   always #5 clk = ~clk;

   pdh_ctrl #(.N_IN(N_IN), .N_OUT(N_OUT), .SYNC_STAGES(SYNC)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .pd_feature_en_i(en),
      .pd_pin_a_i(pa), .pd_pin_b_i(pb), .pad_in_i(pad_in),
      .core_in_o(core_in), .pin_logic_o(pin_logic), .core_clk_en_o(clk_en),
      .core_out_i(c_out), .core_oe_i(c_oe), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
   );

   function automatic logic [7:0] pick(input logic hold, input logic [7:0] snap, input logic [7:0] live);
      return hold ? snap : live;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // model update at each rising edge, from the spec latency of SYNC+1 edges
   always @(posedge clk) begin
      if (!rst_n) begin
         hist <= '0; act_exp <= 1'b0;
      end else begin
         logic [SYNC:0] h;
         h = {hist[SYNC-1:0], en && (pa || pb)};
         hist <= h;
         if (h[SYNC] && !act_exp) begin
            snap_in <= pad_in; snap_out <= c_out; snap_oe <= c_oe;
         end
         act_exp <= h[SYNC];
      end
   end

   task automatic check_all(input string clk_tag);
      chk(clk_tag, 32'(clk_en), 32'(!act_exp));
      chk(act_exp ? "R5" : "R1", 32'(core_in), 32'(pick(act_exp, snap_in, pad_in)));
      chk(act_exp ? "R6" : "R1", 32'(pad_out), 32'(pick(act_exp, snap_out, c_out)));
      chk(act_exp ? "R7" : "R1", 32'(pad_oe), 32'(pick(act_exp, snap_oe, c_oe)));
      chk(en ? "R4" : "R3", 32'(pin_logic), en ? 32'd0 : 32'({pb, pa}));
   endtask

   // one cycle: new inputs after the falling edge, then check before the next rise
   task automatic cyc(input string clk_tag);
      @(negedge clk);
      pad_in = 8'($urandom); c_out = 8'($urandom); c_oe = 8'($urandom);
      #1 check_all(clk_tag);
   endtask

   initial begin : watchdog
      #1000000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      #1 check_all("R1");                    // R1: reset state, live pass-through
      rst_n = 1'b1;
      repeat (3) cyc("R1");

      // R3: disarmed, pins toggle but no hold
      en = 0;
      for (int i = 0; i < 8; i++) begin pa = i[0]; pb = i[1]; cyc("R3"); end
      pa = 0; pb = 0; repeat (4) cyc("R3");

      // R2: arm, pin B alone starts the hold after SYNC+1 edges
      en = 1; pb = 1;
      repeat (SYNC + 4) cyc("R2");
      // R10: raise A, drop B; hold must persist
      pa = 1; cyc("R10"); pb = 0;
      repeat (SYNC + 3) cyc("R10");
      // R9: drop A, release after SYNC+1 edges
      pa = 0;
      repeat (SYNC + 4) cyc("R9");

      // R7: enter with all pads disabled, stay disabled
      @(negedge clk); c_oe = '0; pa = 1;
      for (int i = 0; i < SYNC + 1; i++) begin @(negedge clk); c_oe = '0; #1 check_all("R7"); end
      repeat (6) cyc("R8");
      pa = 0; repeat (SYNC + 3) cyc("R9");

      // random phase
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 15) == 0) pa = ~pa;
         if ($urandom_range(0, 19) == 0) pb = ~pb;
         if ($urandom_range(0, 99) == 0) en = ~en;
         cyc("R8");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule